// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between an on-chip request port and an external byte-wide asynchronous static RAM with a 19-bit address. It takes one read or write per request and turns it into a timed sequence on the RAM's address lines and its three active-low strobes: select, output enable and write enable. It also drives an enable for the pad drivers of the shared data bus. Read data is captured inside the block and returned with a one-cycle acknowledge pulse. A write is acknowledged the same way once its hold cycle is over.

Every analogue timing figure is a nanosecond parameter. Each one is turned into a whole number of clock cycles from the clock-period parameter: the ceiling of the quotient, never less than one. A write is framed by select and write enable both being low, and both strobes are released on the same edge. Output enable stays high for the whole write. The block never turns its own drivers on until the RAM has had its release time since output enable last went high, so the two sides never drive the bus at once. Between accesses the RAM is left deselected so that it can sit in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: A synchronous active-low reset forces select, output enable and write enable high, the data driver enable low, the acknowledge low and the request ready high.
- R2: While no access is in progress, select is high, the data drivers are off and ready is high. Ready is low in every cycle in which select is low.
- R3: A read holds select and output enable low, with write enable high, for RD_CYC consecutive cycles. RD_CYC is the ceiling of the larger of the read cycle time and the access time (70 ns) over the clock period, which is 7 at 10 ns. The address is unchanged throughout.
- R4: Read data is sampled from the bus on the last cycle of the read window. It is returned on the read data output together with a one-cycle acknowledge in the first cycle after select and output enable rise.
- R5: After a read, ready stays low for HZ_CYC cycles, counted from the cycle in which output enable rises. HZ_CYC is the ceiling of the 25 ns release time over the period, which is 3 at 10 ns. The data drivers are never enabled before HZ_CYC full cycles have passed with output enable high.
- R6: A write starts with one setup cycle: select low, write enable high, data drivers on. Write enable is then low for WE_CYC cycles, which is 6 at 10 ns: the largest of the pulse-width, select-to-end, address-to-end and data-setup figures in cycles, and enough for the write cycle time. Select and write enable then rise on the same edge.
- R7: Output enable is high during every cycle of a write, and the data drivers are never on while output enable is low.
- R8: For one cycle after write enable rises, the address and write data are held and the drivers stay on. The drivers are off in the following cycle.
- R9: A write is acknowledged with a one-cycle pulse in the cycle after the hold cycle, and ready is high in that same cycle.
- R10: A request presented while ready is low is ignored. It causes no RAM access and is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid after a read |
| mem_addr | output | ADDR_W | RAM address lines |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | DATA_W | Data toward the bus pad drivers |
| mem_dq_oe | output | 1 | Enable of the bus pad drivers |
| mem_dq_in | input | DATA_W | Data received from the bus |

## Verification
A wrong sequencer state or a wrong timer count shows up at the strobes or at ready in the very cycle it takes effect. The bench predicts every strobe, the driver enable, ready and the acknowledge for each cycle, so a window that is one cycle too long or too short is seen at its first or last edge. A read sampled too early returns the bench RAM's not-yet-valid pattern at the acknowledge. A write that lands at the wrong address or with the wrong data is seen when the location is read back.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the asynchronous SRAM controller.
// Assumes: timing figures are whole nanoseconds and the clock period is a
// positive whole number of nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RREC,
        ST_WSET,
        ST_WPUL,
        ST_WHLD
    } st_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } pins_t;

    // Nanoseconds to cycles: ceiling of the quotient, at least one.
    function automatic int ns2cyc(input int ns, input int per);
        int c;
        c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels that belong to each state.
    function automatic pins_t decode(input st_t s);
        pins_t p;
        p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
        case (s)
            ST_RD:   begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
            ST_WSET: begin p.ce_n = 1'b0; p.dq_oe = 1'b1; end
            ST_WPUL: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.dq_oe = 1'b1; end
            ST_WHLD: p.dq_oe = 1'b1;
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
// Down-counter that times each phase of an access.
// Assumes: it is loaded on the edge that enters a phase with the phase
// length minus one. done is high in the last cycle of the phase.
module sram_ctrl_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Load a new phase length or count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
// Access sequencer: accepts a request in idle, steps through the read or
// write phases, and registers the RAM strobes from the next state so that
// the pins come straight from flops.
// Assumes: phase lengths are at least one cycle and fit in CNT_W bits.
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC = 7,
    parameter int WE_CYC = 6,
    parameter int HZ_CYC = 3,
    parameter int CNT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_done,
    output logic             req_ready,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             capture,
    output logic             rsp_valid,
    output pins_t            pins
);
    st_t  state, nxt;
    logic ack;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;

    // Next state, timer loads and completion events.
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        ack      = 1'b0;
        case (state)
            ST_IDLE: if (req_valid) begin
                if (req_write) begin
                    nxt = ST_WSET;
                end else begin
                    nxt      = ST_RD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RD_CYC - 1);
                end
            end
            ST_RD: if (tmr_done) begin
                nxt      = ST_RREC;
                capture  = 1'b1;
                ack      = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(HZ_CYC - 1);
            end
            ST_RREC: if (tmr_done) nxt = ST_IDLE;
            ST_WSET: begin
                nxt      = ST_WPUL;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WE_CYC - 1);
            end
            ST_WPUL: if (tmr_done) nxt = ST_WHLD;
            ST_WHLD: begin
                nxt = ST_IDLE;
                ack = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State, registered pin levels and acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pins      <= decode(ST_IDLE);
            rsp_valid <= 1'b0;
        end else begin
            state     <= nxt;
            pins      <= decode(nxt);
            rsp_valid <= ack;
        end
    end
endmodule

// File: rtl/sram_ctrl_datapath.sv
// Address, write data and read data registers.
// Assumes: accept and capture come from the sequencer. The bus input is
// settled by the edge at which capture is high.
module sram_ctrl_datapath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rsp_rdata
);
    // Latch the request fields when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Take the bus value on the last cycle of the read window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_rdata <= '0;
        else if (capture)
            rsp_rdata <= mem_dq_in;
    end
endmodule

// File: rtl/sram_async_ctrl.sv
// Top of the asynchronous SRAM controller. Turns single read/write requests
// into strobe sequences whose lengths come from nanosecond parameters.
// Assumes: the bus pads sit outside, driven by mem_dq_out and gated by
// mem_dq_oe, and mem_dq_in is the received pad value.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 10,
    parameter int T_RC_NS  = 70,
    parameter int T_AA_NS  = 70,
    parameter int T_WC_NS  = 70,
    parameter int T_PWE_NS = 55,
    parameter int T_SCE_NS = 60,
    parameter int T_AW_NS  = 60,
    parameter int T_SD_NS  = 30,
    parameter int T_HZ_NS  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int RD_CYC = imax(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS));
    localparam int WE_CYC = imax(imax(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_SCE_NS, CLK_NS)),
                                 imax(imax(ns2cyc(T_AW_NS, CLK_NS), ns2cyc(T_SD_NS, CLK_NS)),
                                      ns2cyc(T_WC_NS, CLK_NS) - 2));
    localparam int HZ_CYC = ns2cyc(T_HZ_NS, CLK_NS);
    localparam int MAX_CYC = imax(imax(RD_CYC, WE_CYC), HZ_CYC);
    localparam int CNT_W  = $clog2(MAX_CYC + 1);

    logic             accept, capture, tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    pins_t            pins;

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    sram_ctrl_fsm #(
        .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .HZ_CYC(HZ_CYC), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .tmr_done(tmr_done), .req_ready(req_ready), .accept(accept),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .capture(capture),
        .rsp_valid(rsp_valid), .pins(pins)
    );

    sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .rsp_rdata(rsp_rdata)
    );

    assign mem_ce_n  = pins.ce_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.dq_oe;
endmodule

// File: rtl/sram_ctrl_checker.sv
// Protocol checker for the SRAM controller, bound to the top module.
// Assumes: the pin outputs are registered and change only at clock edges.
module sram_ctrl_checker #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int HZ_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    int oe_high_cnt;

    // Count the cycles output enable has been high, saturating at HZ_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n)
            oe_high_cnt <= HZ_CYC;
        else if (!mem_oe_n)
            oe_high_cnt <= 0;
        else if (oe_high_cnt < HZ_CYC)
            oe_high_cnt <= oe_high_cnt + 1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid));

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |=> $stable(mem_addr));

    assert_release_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (oe_high_cnt >= HZ_CYC));

    assert_we_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    assert_joint_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> $rose(mem_ce_n));

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)));

    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind sram_async_ctrl sram_ctrl_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HZ_CYC(HZ_CYC)
) u_checker (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
// Bench: behavioural RAM, a per-cycle expected-pin queue, a compare on
// every clock.
module test_sram_async_ctrl;
    localparam int CLK_PERIOD_NS = 10;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int RD = (cyc(70) > cyc(70)) ? cyc(70) : cyc(70);
    localparam int WE = 6;   // 60 ns select/address-to-end dominates at 10 ns
    localparam int HZ = 3;   // 25 ns release

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD_NS/2) clk = ~clk;

    sram_async_ctrl #(.CLK_NS(CLK_PERIOD_NS)) i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] dflt(input logic [18:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction

    // ---------------- behavioural RAM ----------------
    logic [7:0]  ram [int];
    int          win = 0;
    bit          wr_act = 0;
    logic [18:0] wr_a;
    logic [7:0]  wr_d;

    function automatic logic [7:0] ram_rd(input logic [18:0] a);
        return ram.exists(int'(a)) ? ram[int'(a)] : dflt(a);
    endfunction

    always @(negedge clk) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n) win++; else win = 0;
        if (!mem_ce_n && !mem_we_n) begin
            wr_act = 1; wr_a = mem_addr; wr_d = mem_dq_out;
        end else if (wr_act) begin
            ram[int'(wr_a)] = wr_d; wr_act = 0;
        end
        if (win >= RD)     mem_dq_in = ram_rd(mem_addr);
        else if (win > 0)  mem_dq_in = ~ram_rd(mem_addr);
        else               mem_dq_in = 8'hEE;
    end

    // ---------------- reference model ----------------
    typedef struct {
        bit ce, oe, we, dq, rdy, rv, rd, ca, cd;
        logic [18:0] a;
        logic [7:0]  d;
        string tag;
    } exp_t;

    exp_t       q[$];
    exp_t       cur;
    logic [7:0] sm [int];

    function automatic exp_t mk(bit ce, bit oe, bit we, bit dq, bit rdy, bit rv,
                                bit rd, bit ca, bit cd, logic [18:0] a, logic [7:0] d, string tag);
        exp_t e;
        e.ce = ce; e.oe = oe; e.we = we; e.dq = dq; e.rdy = rdy; e.rv = rv;
        e.rd = rd; e.ca = ca; e.cd = cd; e.a = a; e.d = d; e.tag = tag;
        return e;
    endfunction

    function automatic void push_op(bit w, logic [18:0] a, logic [7:0] d);
        logic [7:0] e;
        if (w) begin
            sm[int'(a)] = d;
            q.push_back(mk(0,1,1,1,0,0,0,1,1,a,d,"R6"));
            for (int i = 0; i < WE; i++) q.push_back(mk(0,1,0,1,0,0,0,1,1,a,d,"R7"));
            q.push_back(mk(1,1,1,1,0,0,0,1,1,a,d,"R8"));
            q.push_back(mk(1,1,1,0,1,1,0,0,0,a,d,"R9"));
        end else begin
            e = sm.exists(int'(a)) ? sm[int'(a)] : dflt(a);
            for (int i = 0; i < RD; i++) q.push_back(mk(0,0,1,0,0,0,0,1,0,a,e,"R3"));
            q.push_back(mk(1,1,1,0,0,1,1,0,0,a,e,"R4"));
            for (int i = 1; i < HZ; i++) q.push_back(mk(1,1,1,0,0,0,0,0,0,a,e,"R5"));
        end
    endfunction

    initial cur = mk(1,1,1,0,1,0,0,0,0,'0,'0,"R2");

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            cur = mk(1,1,1,0,1,0,0,0,0,'0,'0,"R2");
        end else begin
            if (cur.rdy && req_valid) push_op(req_write, req_addr, req_wdata);
            if (q.size() > 0) cur = q.pop_front();
            else cur = mk(1,1,1,0,1,0,0,0,0,'0,'0,"R2");
        end
    end

    bit cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(cur.tag, "ce_n",  mem_ce_n,  cur.ce);
            chk(cur.tag, "oe_n",  mem_oe_n,  cur.oe);
            chk(cur.tag, "we_n",  mem_we_n,  cur.we);
            chk(cur.tag, "dq_oe", mem_dq_oe, cur.dq);
            chk(cur.tag, "ready", req_ready, cur.rdy);
            chk(cur.tag, "rsp_valid", rsp_valid, cur.rv);
            if (cur.ca) chk(cur.tag, "addr", mem_addr, cur.a);
            if (cur.cd) chk(cur.tag, "dq_out", mem_dq_out, cur.d);
            if (cur.rd) chk(cur.tag, "rdata", rsp_rdata, cur.d);
        end
    end

    // ---------------- stimulus ----------------
    // Called just after a negedge; returns just after the negedge following acceptance.
    task automatic req(input bit w, input logic [18:0] a, input logic [7:0] d);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic settle();
        repeat (14) @(negedge clk);
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: state right after reset
        chk("R1", "ce_n", mem_ce_n, 1);
        chk("R1", "oe_n", mem_oe_n, 1);
        chk("R1", "we_n", mem_we_n, 1);
        chk("R1", "dq_oe", mem_dq_oe, 0);
        chk("R1", "ready", req_ready, 1);
        chk("R1", "rsp_valid", rsp_valid, 0);
        cmp_on = 1;

        req(1, 19'h00000, 8'hA5); settle();
        req(1, 19'h7FFFF, 8'hFF); settle();
        req(1, 19'h12345, 8'h00); settle();
        req(0, 19'h7FFFF, 8'h00); settle();
        req(0, 19'h00000, 8'h00); settle();
        req(0, 19'h12345, 8'h00); settle();
        req(0, 19'h00100, 8'h00); settle();   // never written

        // back-to-back: valid stays high across requests
        req(1, 19'h55555, 8'h5A);
        req(0, 19'h55555, 8'h00);
        req(1, 19'h2AAAA, 8'hC3);
        req(0, 19'h2AAAA, 8'h00);
        settle();

        // R10: a request offered while busy is dropped
        req(0, 19'h00000, 8'h00);
        req_valid = 1; req_write = 1; req_addr = 19'h33333; req_wdata = 8'h77;
        @(negedge clk);
        req_valid = 0;
        settle();
        chk("R10", "ce_n idle after dropped request", mem_ce_n, 1);
        chk("R10", "no ack pending", rsp_valid, 0);
        req(0, 19'h33333, 8'h00); settle();   // expects the unwritten pattern

        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end
endmodule